// File: doc/BRIEF.md
# Daisy-Chain Bus Grant Requester

This block is a single link in a serial grant chain. Every bus master has one. A grant enters from the upstream link, and a local master raises a request. The link decides exactly once whether it keeps that grant for its own master or hands it on through its grant output to the next link. While it holds the bus it drives a bus-busy line. While its master is waiting it drives the shared bus-request line that wakes the central arbiter.

The incoming grant and the local request are asynchronous to the link's clock and to each other. Both pass through a flop synchronizer of `SYNC_STAGES` stages before the state machine sees them. The keep-or-forward choice is taken in one dedicated state from the synchronized values. It stays locked until the incoming grant falls. A request edge and a grant edge that arrive together therefore give a single, repeatable outcome, and they can never give both a kept grant and a forwarded one.

States are IDLE, DECIDE, OWN, PASS and DONE. The transitions are:
- IDLE to DECIDE when the synchronized grant is high.
- DECIDE to OWN when the synchronized request is high, otherwise DECIDE to PASS.
- OWN to DONE when the request falls while the grant is still high.
- OWN to IDLE when the request falls with the grant already low.
- PASS to IDLE when the grant falls.
- DONE to IDLE when the grant falls.

Top module: `grant_chain_node`

## Requirements
- R1: While rst_n is low, grant_out, bus_busy and bus_req are all low, whatever grant_in and req_in do.
- R2: With SYNC_STAGES = S, the link makes no visible response before the (S+2)-th rising edge after grant_in rises. At that edge, either grant_out or bus_busy goes high.
- R3: If the synchronized request is high when the decision is taken, the link enters OWN. bus_busy then stays high and grant_out stays low until the request is withdrawn, even if grant_in falls first.
- R4: If the synchronized request is low when the decision is taken, the link enters PASS. grant_out goes high and bus_busy stays low.
- R5: When req_in and grant_in rise in the same clock period, the link always keeps the grant (OWN). It never forwards the grant and owns the bus at the same time.
- R6: A request that reaches the synchronizer output after the decision is not served on the current grant. The link stays in PASS until grant_in falls, and it takes the bus on the next grant.
- R7: bus_req is high exactly when the synchronized request is high and the link is not in OWN.
- R8: bus_busy falls at the (S+1)-th rising edge after req_in falls while the link is in OWN.
- R9: If the request is withdrawn while grant_in is still high, grant_out stays low (DONE) until grant_in falls. The link then returns to IDLE and handles a new grant normally.
- R10: In PASS, grant_out falls at the (S+1)-th rising edge after grant_in falls.
- R11: In a chain of links fed by one arbiter, at most one link drives bus_busy at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| grant_in | input | 1 | Grant from the upstream link or the arbiter, asynchronous |
| req_in | input | 1 | Request from the local master, asynchronous |
| grant_out | output | 1 | Grant forwarded to the downstream link |
| bus_busy | output | 1 | High while this link owns the bus |
| bus_req | output | 1 | Contribution to the shared bus-request line |

## Verification
The assertions watch the synchronized inputs, not the raw pins. They therefore assume that grant_in and req_in are stable for at least one clock. They also assume that the arbiter does not raise a grant and drop it again before the decision settles.

The single-link bench moves inputs only on falling edges. It sweeps the request offset against the grant from several periods early to several periods late, and holds each level long enough to cross the synchronizer.

In the chain run, the arbiter model raises a grant only when no link is busy and no grant is still travelling the chain. It drops the grant once a link is busy or once the grant has left the last link, and then waits before granting again. This keeps every link within those assumptions.

// File: rtl/gcn_pkg.sv
package gcn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DECIDE = 3'd1,
        ST_OWN    = 3'd2,
        ST_PASS   = 3'd3,
        ST_DONE   = 3'd4
    } node_state_t;

endpackage

// File: rtl/gcn_sync.sv
module gcn_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/gcn_fsm.sv
module gcn_fsm
    import gcn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gnt_s,
    input  logic req_s,
    output logic grant_out,
    output logic bus_busy,
    output logic bus_req
);

    node_state_t state, state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (gnt_s)  state_nxt = ST_DECIDE;
            ST_DECIDE: state_nxt = req_s ? ST_OWN : ST_PASS;
            ST_OWN:    if (!req_s) state_nxt = gnt_s ? ST_DONE : ST_IDLE;
            ST_PASS:   if (!gnt_s) state_nxt = ST_IDLE;
            ST_DONE:   if (!gnt_s) state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        grant_out = 1'b0;
        bus_busy  = 1'b0;
        bus_req   = req_s;
        unique case (state)
            ST_OWN:  begin bus_busy = 1'b1; bus_req = 1'b0; end
            ST_PASS: grant_out = 1'b1;
            default: ;
        endcase
    end

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE && req_s) |=> (bus_busy && !grant_out));

    assert_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE && !req_s) |=> (grant_out && !bus_busy));

    assert_decision_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && gnt_s) |=> (state == ST_PASS));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OWN && !req_s) |=> !bus_busy);

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && gnt_s) |=> !grant_out);

    assert_pass_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && !gnt_s) |=> !grant_out);

    assert_own_only_via_decide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DECIDE && state != ST_OWN) |=> (state != ST_OWN));

endmodule

// File: rtl/grant_chain_node.sv
module grant_chain_node #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_in,
    input  logic req_in,
    output logic grant_out,
    output logic bus_busy,
    output logic bus_req
);

    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] sync_out;

    assign raw_in = {req_in, grant_in};

    gcn_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (SYNC_W)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    gcn_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt_s     (sync_out[0]),
        .req_s     (sync_out[1]),
        .grant_out (grant_out),
        .bus_busy  (bus_busy),
        .bus_req   (bus_req)
    );

    assert_not_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_busy) |-> !grant_out);

endmodule

// File: tb/grant_chain_node_bench.sv
module grant_chain_node_bench;

    localparam int SYNC     = 2;
    localparam int LAT_DEC  = SYNC + 2;
    localparam int LAT_REL  = SYNC + 1;
    localparam int LAST_CAP = SYNC - 1;
    localparam int NODES    = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, g_in, r_in;
    logic g_out, busy, breq;

    grant_chain_node #(.SYNC_STAGES(SYNC)) u_grant_chain_node (
        .clk(clk), .rst_n(rst_n), .grant_in(g_in), .req_in(r_in),
        .grant_out(g_out), .bus_busy(busy), .bus_req(breq)
    );

    // chain of links sharing one arbiter
    logic             c_g0;
    logic [NODES-1:0] c_req, c_gout, c_busy, c_breq;

    for (genvar i = 0; i < NODES; i++) begin : g_chain
        logic gin;
        if (i == 0) begin : g_head
            assign gin = c_g0;
        end else begin : g_link
            assign gin = c_gout[i-1];
        end
        grant_chain_node #(.SYNC_STAGES(SYNC)) u_link (
            .clk(clk), .rst_n(rst_n), .grant_in(gin), .req_in(c_req[i]),
            .grant_out(c_gout[i]), .bus_busy(c_busy[i]), .bus_req(c_breq[i])
        );
    end

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // request offset d (clock periods) relative to grant rise
    task automatic sweep_trial(input int d);
        logic cap;
        cap = (d <= LAST_CAP);
        if (d < 0) begin
            r_in = 1'b1;
            tick(-d);
            if (d <= -SYNC) begin
                chk(breq, 1'b1, $sformatf("R7 request line before grant d=%0d", d));
                chk(g_out, 1'b0, $sformatf("R7 no grant out before grant d=%0d", d));
            end
        end
        g_in = 1'b1;
        if (d == 0) r_in = 1'b1;
        if (d > 0) begin
            tick(d);
            r_in = 1'b1;
            tick(LAT_DEC - d);
        end else begin
            tick(LAT_DEC - 1);
            chk(g_out | busy, 1'b0, $sformatf("R2 no response before decision d=%0d", d));
            tick(1);
        end
        if (d == 0) begin
            chk(busy, 1'b1, "R5 coincident edges keep grant");
            chk(g_out, 1'b0, "R5 coincident edges do not forward");
        end else begin
            chk(busy, cap, $sformatf("%s busy at decision d=%0d", cap ? "R3" : "R4", d));
            chk(g_out, !cap, $sformatf("%s grant_out at decision d=%0d", cap ? "R3" : "R4", d));
        end
        tick(2);
        g_in = 1'b0;
        if (cap) begin
            tick(LAT_REL);
            chk(busy, 1'b1, $sformatf("R3 ownership kept after grant falls d=%0d", d));
            chk(breq, 1'b0, $sformatf("R7 request line low while owning d=%0d", d));
            r_in = 1'b0;
            tick(LAT_REL - 1);
            chk(busy, 1'b1, $sformatf("R8 busy before release edge d=%0d", d));
            tick(1);
            chk(busy, 1'b0, $sformatf("R8 busy released d=%0d", d));
        end else begin
            tick(LAT_REL - 1);
            chk(g_out, 1'b1, $sformatf("R10 grant_out held d=%0d", d));
            chk(breq, 1'b1, $sformatf("R7 late request on line d=%0d", d));
            tick(1);
            chk(g_out, 1'b0, $sformatf("R10 grant_out dropped d=%0d", d));
            chk(busy, 1'b0, $sformatf("R6 late request not served d=%0d", d));
            g_in = 1'b1;
            tick(LAT_DEC);
            chk(busy, 1'b1, $sformatf("R6 served on next grant d=%0d", d));
            chk(g_out, 1'b0, $sformatf("R6 next grant kept d=%0d", d));
            g_in = 1'b0;
            r_in = 1'b0;
            tick(LAT_REL);
            chk(busy, 1'b0, $sformatf("R8 released after next grant d=%0d", d));
        end
        tick(4);
    endtask

    task automatic done_trial();
        g_in = 1'b1;
        r_in = 1'b1;
        tick(LAT_DEC);
        chk(busy, 1'b1, "R3 owner before early release");
        r_in = 1'b0;
        tick(LAT_REL);
        chk(busy, 1'b0, "R8 early release");
        chk(g_out, 1'b0, "R9 grant not forwarded after release");
        tick(5);
        chk(g_out, 1'b0, "R9 grant still held back");
        g_in = 1'b0;
        tick(LAT_REL);
        g_in = 1'b1;
        tick(LAT_DEC);
        chk(g_out, 1'b1, "R9 back in idle, forwards new grant");
        g_in = 1'b0;
        tick(LAT_REL + 2);
    endtask

    task automatic run_chain(input int cycles);
        int served [NODES];
        int hold   [NODES];
        int gap    [NODES];
        int over   = 0;
        int both   = 0;
        int settle = 0;
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < NODES; i++) begin
            served[i] = 0; hold[i] = 0; gap[i] = i * 7;
        end
        for (int cyc = 0; cyc < cycles; cyc++) begin
            @(negedge clk);
            if ($countones(c_busy) > 1) over++;
            if ((c_busy & c_gout) != '0) both++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            for (int i = 0; i < NODES; i++) begin
                if (c_req[i]) begin
                    if (c_busy[i]) hold[i]++;
                    if (hold[i] >= 3) begin
                        c_req[i]  = 1'b0;
                        served[i]++;
                        gap[i]    = 30 + int'(lfsr[4:0]);
                    end
                end else if (gap[i] > 0) begin
                    gap[i]--;
                end else if (lfsr[i]) begin
                    c_req[i] = 1'b1;
                    hold[i]  = 0;
                end
            end
            if (c_g0) begin
                if ((|c_busy) || c_gout[NODES-1]) begin
                    c_g0   = 1'b0;
                    settle = 4;
                end
            end else if (settle > 0) begin
                settle--;
            end else if (!(|c_busy) && (|c_breq) && !(|c_gout)) begin
                c_g0 = 1'b1;
            end
        end
        chk(over == 0, 1'b1, $sformatf("R11 at most one owner in chain, violations %0d", over));
        chk(both == 0, 1'b1, $sformatf("R5 no link owns and forwards at once, violations %0d", both));
        for (int i = 0; i < NODES; i++) begin
            chk(served[i] > 0, 1'b1, $sformatf("R3 chain link %0d obtained bus %0d times", i, served[i]));
        end
    endtask

    initial begin
        rst_n = 1'b0;
        g_in  = 1'b1;
        r_in  = 1'b1;
        c_g0  = 1'b0;
        c_req = '0;
        tick(4);
        chk(g_out, 1'b0, "R1 grant_out in reset");
        chk(busy, 1'b0, "R1 bus_busy in reset");
        chk(breq, 1'b0, "R1 bus_req in reset");
        g_in = 1'b0;
        r_in = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        chk(g_out | busy | breq, 1'b0, "R1 quiet after reset");
        for (int d = -3; d <= LAT_DEC; d++) begin
            sweep_trial(d);
        end
        done_trial();
        run_chain(6000);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule